// File: doc/BRIEF.md
# Dual-Channel IDE Interrupt Status Latch

This block keeps track of pending interrupts for a two-channel IDE host controller. Each channel's drive interrupt line is synchronized into the host clock domain. A rising edge on that line latches a pending flag in a shared mode/status byte. The same edge sets the INTR flag in that channel's bus-master DMA status byte, so the two views stay in step.

Software reaches all three bytes through one byte-wide register port, selected by a two-bit address. It clears the flags by writing ones to them. The mode/status byte also holds control bits: two of them can be read back, and two are write-only, one of which enables interrupts. The host interrupt request is raised only for a channel whose pending flag and DMA INTR flag are both set, and only while interrupts are enabled. Each DMA status byte also has an ERROR flag, which is set by a one-cycle pulse from the DMA engine of that channel.

Top module: `ide_irq_latch`

## Requirements
- R1: After reset, every flag, the interrupt enable and the control bits are 0. Every address reads 0x00, and `irq` is low.
- R2: A rising edge on `intrq[c]` passes through a synchronizer of `SYNC_STAGES` flops. With the default of 2, the pending flag is readable after the third rising clock edge that follows the input change. A level that stays high does not set the flag again once it has been cleared.
- R3: At address 0, the channel 0 pending flag is bit 2 and the channel 1 pending flag is bit 3. Writing 1 to either bit clears that flag.
- R4: Writing 0 to a pending-flag bit at address 0 leaves that flag unchanged, so clearing one channel never clears the other.
- R5: Bits 5:4 of address 0 are ordinary control bits that can be written and read back. Bits 7:6 always read 0.
- R6: Bits 1:0 of address 0 always read 0, whatever was last written to them. Bit 1, when written, loads the interrupt enable.
- R7: Address 1 is the DMA status of channel 0, and address 2 is the DMA status of channel 1. In each, bit 2 (INTR) sets on the same edge event as the pending flag, and bit 1 (ERROR) sets from a pulse on `dma_err[c]`. Writing 1 to either bit clears it, and writing 0 leaves it unchanged. All other bits, and address 3, read 0.
- R8: `irq` is high exactly when the interrupt enable is set and at least one channel has both its pending flag and its DMA INTR flag set.
- R9: When a flag's set and clear occur in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| intrq | input | 2 | Drive interrupt lines, one per channel (asynchronous) |
| dma_err | input | 2 | One-cycle error pulses from each channel's DMA engine |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select: 0 mode/status, 1 ch0 DMA status, 2 ch1 DMA status |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| irq | output | 1 | Combined host interrupt request |

## Verification
A pending flag stored in the wrong state shows up in two places. It appears on the next read of address 0. Unless the enable is off or the matching DMA INTR flag is clear, it also appears at once on `irq`, because `irq` is formed from the registers with no further delay. A flag latched by the wrong channel, or one that is cleared by a write of 0, can be seen one cycle after the offending edge or write. A synchronizer that is too short or too long moves the first visible set away from the third clock edge. A same-cycle set/clear collision that resolves the wrong way leaves a flag cleared that should read back as 1.

// File: rtl/ide_irq_latch.sv
module ide_irq_latch #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] intrq,
  input  logic [1:0] dma_err,
  input  logic       wr_en,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq
);

  localparam int SW = 2 * SYNC_STAGES;

  logic [SW-1:0] sync_q;
  logic [1:0]    seen_q, edge_ev;
  logic [1:0]    pend_q, intr_q, err_q;
  logic          ien_q;
  logic [1:0]    ctl_q;
  logic          wr_mode;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync_q <= '0;
      seen_q <= '0;
    end else begin
      sync_q <= {sync_q[SW-3:0], intrq};
      seen_q <= sync_q[SW-1:SW-2];
    end

  assign edge_ev = sync_q[SW-1:SW-2] & ~seen_q;
  assign wr_mode = wr_en && addr == 2'd0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ien_q <= 1'b0;
      ctl_q <= '0;
    end else if (wr_mode) begin
      ien_q <= wdata[1];
      ctl_q <= wdata[5:4];
    end

  for (genvar c = 0; c < 2; c++) begin : g_ch
    logic wr_dma;
    assign wr_dma = wr_en && addr == 2'(c + 1);

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        pend_q[c] <= 1'b0;
        intr_q[c] <= 1'b0;
        err_q[c]  <= 1'b0;
      end else begin
        pend_q[c] <= edge_ev[c] | (pend_q[c] & ~(wr_mode & wdata[2+c]));
        intr_q[c] <= edge_ev[c] | (intr_q[c] & ~(wr_dma & wdata[2]));
        err_q[c]  <= dma_err[c] | (err_q[c] & ~(wr_dma & wdata[1]));
      end

    p_pend_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      edge_ev[c] |=> pend_q[c] && intr_q[c]);
    p_pend_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_mode && wdata[2+c] && !edge_ev[c]) |=> !pend_q[c]);
    p_pend_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q[c] && !(wr_mode && wdata[2+c])) |=> pend_q[c]);
    p_err_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
      dma_err[c] |=> err_q[c]);
  end

  always_comb
    case (addr)
      2'd0:    rdata = {2'b00, ctl_q, pend_q, 2'b00};
      2'd1:    rdata = {5'b0, intr_q[0], err_q[0], 1'b0};
      2'd2:    rdata = {5'b0, intr_q[1], err_q[1], 1'b0};
      default: rdata = 8'h00;
    endcase

  assign irq = ien_q & |(pend_q & intr_q);

  p_wo_read_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    addr == 2'd0 |-> rdata[1:0] == 2'b00);
  p_disable_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mode && !wdata[1]) |=> !irq);
  p_irq_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (rdata != 8'hFF) && |(pend_q & intr_q));

endmodule

// File: tb/test_ide_irq_latch.sv
module test_ide_irq_latch;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] intrq = '0;
  logic [1:0] dma_err = '0;
  logic       wr_en = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq;
  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  ide_irq_latch i_ide_irq_latch (
    .clk(clk), .rst_n(rst_n), .intrq(intrq), .dma_err(dma_err),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
    addr = a;
    #1;
    check(rdata, exp, tag);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic pulse_intrq(input int c);
    intrq[c] = 1'b1;
    wait_clk(4);
    intrq[c] = 1'b0;
    wait_clk(4);
  endtask

  task automatic t_reset;
    for (int a = 0; a < 4; a++) rd(2'(a), 8'h00, "R1 reset read");
    check({7'b0, irq}, 8'h00, "R1 reset irq");
  endtask

  task automatic t_capture_latency;
    intrq[0] = 1'b1;
    wait_clk(2);
    rd(2'd0, 8'h00, "R2 not yet visible after two edges");
    wait_clk(1);
    rd(2'd0, 8'h04, "R2 visible after third edge");
    intrq[0] = 1'b0;
    wait_clk(4);
    rd(2'd1, 8'h04, "R7 ch0 INTR mirrors pending");
    rd(2'd2, 8'h00, "R7 ch1 DMA status untouched");
    check({7'b0, irq}, 8'h00, "R8 irq off while disabled");
  endtask

  task automatic t_enable;
    wr(2'd0, 8'h02);
    rd(2'd0, 8'h04, "R6 write-only bit reads 0, R4 pending kept");
    check({7'b0, irq}, 8'h01, "R8 irq with enable and both flags");
  endtask

  task automatic t_isolation;
    pulse_intrq(1);
    rd(2'd0, 8'h0C, "R2 ch1 pending set");
    wr(2'd0, 8'h06);
    rd(2'd0, 8'h08, "R3 ch0 cleared, R4 ch1 kept");
    rd(2'd1, 8'h04, "R7 ch0 INTR kept after mode write");
    check({7'b0, irq}, 8'h01, "R8 irq from ch1");
    wr(2'd0, 8'h0A);
    rd(2'd0, 8'h00, "R3 ch1 cleared");
    check({7'b0, irq}, 8'h00, "R8 irq needs pending and INTR");
    wr(2'd2, 8'h00);
    rd(2'd2, 8'h04, "R7 write 0 keeps INTR");
    wr(2'd2, 8'h04);
    rd(2'd2, 8'h00, "R7 INTR write-one clear");
    wr(2'd1, 8'h04);
    rd(2'd1, 8'h00, "R7 ch0 INTR clear");
  endtask

  task automatic t_level_hold;
    intrq[0] = 1'b1;
    wait_clk(4);
    wr(2'd0, 8'h06);
    wait_clk(6);
    rd(2'd0, 8'h00, "R2 held level does not retrigger");
    intrq[0] = 1'b0;
    wait_clk(4);
    wr(2'd1, 8'h04);
  endtask

  task automatic t_ctl;
    wr(2'd0, 8'hF3);
    rd(2'd0, 8'h30, "R5 control bits read back, R6 low bits 0");
    wr(2'd0, 8'h10);
    rd(2'd0, 8'h10, "R5 control bits rewrite");
    rd(2'd3, 8'h00, "R7 address 3 reads 0");
    wr(2'd0, 8'h02);
  endtask

  task automatic t_err;
    dma_err[1] = 1'b1;
    wait_clk(1);
    dma_err[1] = 1'b0;
    rd(2'd2, 8'h02, "R7 ERROR set by pulse");
    rd(2'd1, 8'h00, "R7 other channel ERROR clear");
    check({7'b0, irq}, 8'h00, "R8 ERROR does not raise irq");
    wr(2'd2, 8'h02);
    rd(2'd2, 8'h00, "R7 ERROR write-one clear");
  endtask

  task automatic t_set_wins;
    pulse_intrq(0);
    rd(2'd0, 8'h04, "R9 setup pending");
    intrq[0] = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    addr = 2'd0; wdata = 8'h06; wr_en = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
    rd(2'd0, 8'h04, "R9 set beats same-cycle clear");
    check({7'b0, irq}, 8'h01, "R9 irq after collision");
    intrq[0] = 1'b0;
    wait_clk(4);
    dma_err[0] = 1'b1;
    addr = 2'd1; wdata = 8'h02; wr_en = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0; dma_err[0] = 1'b0;
    rd(2'd1, 8'h06, "R9 ERROR set beats clear");
  endtask

  initial begin
    wait_clk(100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    wait_clk(3);
    t_reset();
    rst_n = 1'b1;
    wait_clk(1);
    t_reset();
    t_capture_latency();
    t_enable();
    t_isolation();
    t_level_hold();
    t_ctl();
    t_err();
    t_set_wins();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule